// File: doc/BRIEF.md
# PLL Control Word Rate Decoder

This block takes the 32-bit control setting of a frequency synthesizer and the frequency of its reference oscillator in hertz. From these it works out the frequency the synthesizer produces. A pulse on `start` captures both inputs. If the setting selects pass-through, the answer is the reference itself. If the setting selects shut-down, the answer is zero. In every other case the block builds a multiplier and a divisor from three packed fields. It forms a wide product and runs a bit-serial restoring divide on it. When the answer is ready, `done` pulses for one cycle and `rate_hz` holds the result until the next computation completes.

Firmware-facing logic or a clock monitor uses this block to report the frequency a given setting will produce. The reference frequency arrives on a port, so the same instance serves a 27 MHz oscillator, a 33.333333 MHz oscillator, or any other source.

Top module: `pll_rate_decoder`

## Requirements
- R1: When bit 1 of the control word (pass-through) is 1, the result equals the reference rate, whatever the value of bit 0.
- R2: When bit 1 is 0 and bit 0 (shut-down) is 1, the result is 0.
- R3: The pre-divider equals the 5-bit field in bits 8:4 plus one, giving a range of 1 to 32.
- R4: The loop multiplier equals two times the 7-bit field in bits 15:9 plus one, giving a range of 2 to 256.
- R5: The post-divider equals 2 raised to the 2-bit field in bits 3:2, giving 1, 2, 4 or 8.
- R6: With bits 1:0 both 0, the result is floor(reference × loop multiplier / (pre-divider × post-divider)). The product is formed at 64 bits and is never truncated.
- R7: Control bits 31:16, which include the band setting, have no effect on the result.
- R8: `done` is high for exactly one cycle. It follows the accepting clock edge by 1 edge on the pass-through and shut-down paths, and by QUO_W+1 edges on the arithmetic path.
- R9: `busy` is high from the edge that accepts a start until `done` rises. `busy` and `done` are never high together.
- R10: A start that arrives while `busy` is high is ignored. `rate_hz` keeps its value except in the cycle `done` rises.
- R11: After reset, `busy` is 0, `done` is 0 and `rate_hz` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start strobe; sampled only while idle |
| ctrl_word | input | 32 | Synthesizer control setting |
| ref_hz | input | 32 | Reference oscillator frequency in Hz |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle pulse when the result is valid |
| rate_hz | output | 64 | Computed output frequency in Hz |

## Verification
A fault in the divider's remainder or shift state produces a wrong `rate_hz` at the very next `done` pulse. Faults in the field slicing or divisor construction show up only for the field combinations that exercise them. For that reason both reference rates are swept against every pre-divider and post-divider value and a spread of loop settings. A step counter that is off by one moves `done` away from its fixed latency. This shows at the first computation, and also as `busy` staying high or dropping early. A control state that accepts starts while working shows as a result that belongs to the wrong control word.

// File: rtl/pll_rate_pkg.sv
package pll_rate_pkg;

    // Bit positions of the control word fields.
    localparam int SHUT_BIT = 0;
    localparam int PASS_BIT = 1;
    localparam int POST_LSB = 2;
    localparam int POST_W   = 2;
    localparam int PRE_LSB  = 4;
    localparam int PRE_W    = 5;
    localparam int LOOP_LSB = 9;
    localparam int LOOP_W   = 7;

    // Highest used bit plus one.
    localparam int USED_W = LOOP_LSB + LOOP_W;

    // Widths of the derived operands.
    localparam int MULT_W = LOOP_W + 2;                         // 2*(f+1) <= 2^(LOOP_W+1)
    localparam int DIVS_W = PRE_W + 1 + (1 << POST_W) - 1;      // (f+1) << 3

    typedef struct packed {
        logic              pass;
        logic              shut;
        logic [POST_W-1:0] post;
        logic [PRE_W-1:0]  pre;
        logic [LOOP_W-1:0] loop;
    } fields_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHORT  = 2'd1,
        ST_DIVIDE = 2'd2
    } ctl_state_e;

endpackage

// File: rtl/pll_field_decode.sv
module pll_field_decode
    import pll_rate_pkg::*;
(
    input  logic [USED_W-1:0] ctrl_low,
    output fields_t           fields,
    output logic [MULT_W-1:0] multiplier,
    output logic [DIVS_W-1:0] divisor
);

    logic [DIVS_W-1:0] pre_eff;

    always_comb begin
        fields.pass = ctrl_low[PASS_BIT];
        fields.shut = ctrl_low[SHUT_BIT];
        fields.post = ctrl_low[POST_LSB +: POST_W];
        fields.pre  = ctrl_low[PRE_LSB  +: PRE_W];
        fields.loop = ctrl_low[LOOP_LSB +: LOOP_W];
    end

    // Loop multiplier: two times (field + 1).
    assign multiplier = {(MULT_W-1)'(fields.loop) + (MULT_W-1)'(1), 1'b0};

    // Pre-divider (field + 1) scaled by the post-divider 2^field.
    assign pre_eff = DIVS_W'(fields.pre) + DIVS_W'(1);
    assign divisor = pre_eff << fields.post;

endmodule

// File: rtl/pll_seq_divider.sv
module pll_seq_divider #(
    parameter int NUM_W = 64,
    parameter int DEN_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [NUM_W-1:0] numer,
    input  logic [DEN_W-1:0] denom,
    output logic [NUM_W-1:0] quot,
    output logic             fin
);

    localparam int CNT_W = (NUM_W > 1) ? $clog2(NUM_W) : 1;
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(NUM_W - 1);

    typedef struct packed {
        logic [DEN_W-1:0] rem;
        logic [NUM_W-1:0] quo;
        logic [DEN_W-1:0] den;
        logic [CNT_W-1:0] cnt;
        logic             run;
        logic             fin;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [DEN_W:0] trial;
    logic           take;

    always_comb begin
        st_d     = st_q;
        st_d.fin = 1'b0;
        trial    = {st_q.rem, st_q.quo[NUM_W-1]};
        take     = (trial >= {1'b0, st_q.den});
        if (go) begin
            st_d.quo = numer;
            st_d.rem = '0;
            st_d.den = denom;
            st_d.cnt = '0;
            st_d.run = 1'b1;
        end else if (st_q.run) begin
            if (take) begin
                st_d.rem = DEN_W'(trial - {1'b0, st_q.den});
            end else begin
                st_d.rem = trial[DEN_W-1:0];
            end
            st_d.quo = {st_q.quo[NUM_W-2:0], take};
            st_d.cnt = st_q.cnt + CNT_W'(1);
            if (st_q.cnt == LAST_STEP) begin
                st_d.run = 1'b0;
                st_d.fin = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign quot = st_q.quo;
    assign fin  = st_q.fin;

    AST_DIVISOR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> (denom != '0));                                   // R3
    AST_REM_BELOW_DEN: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run |-> (st_q.rem < st_q.den));                     // R6
    AST_FIN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> !fin);                                           // R8

endmodule

// File: rtl/pll_rate_decoder.sv
module pll_rate_decoder
    import pll_rate_pkg::*;
#(
    parameter int CTRL_W = 32,
    parameter int REF_W  = 32,
    parameter int RATE_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic [REF_W-1:0]  ref_hz,
    output logic              busy,
    output logic              done,
    output logic [RATE_W-1:0] rate_hz
);

    typedef struct packed {
        ctl_state_e        state;
        logic [RATE_W-1:0] short_val;
        logic [RATE_W-1:0] result;
        logic              done;
    } top_st_t;

    top_st_t st_d, st_q;

    fields_t           fld;
    logic [MULT_W-1:0] mult;
    logic [DIVS_W-1:0] divs;
    logic [RATE_W-1:0] product;
    logic [RATE_W-1:0] div_quot;
    logic              div_fin;
    logic              div_go;
    logic              unused_ctrl_bits;

    assign unused_ctrl_bits = ^ctrl_word[CTRL_W-1:USED_W];

    pll_field_decode i_decode (
        .ctrl_low   (ctrl_word[USED_W-1:0]),
        .fields     (fld),
        .multiplier (mult),
        .divisor    (divs)
    );

    assign product = RATE_W'(ref_hz) * RATE_W'(mult);
    assign div_go  = (st_q.state == ST_IDLE) && start && !fld.pass && !fld.shut;

    pll_seq_divider #(
        .NUM_W (RATE_W),
        .DEN_W (DIVS_W)
    ) i_divider (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (div_go),
        .numer (product),
        .denom (divs),
        .quot  (div_quot),
        .fin   (div_fin)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.state)
            ST_IDLE: begin
                if (start) begin
                    if (fld.pass) begin
                        st_d.short_val = RATE_W'(ref_hz);
                        st_d.state     = ST_SHORT;
                    end else if (fld.shut) begin
                        st_d.short_val = '0;
                        st_d.state     = ST_SHORT;
                    end else begin
                        st_d.state     = ST_DIVIDE;
                    end
                end
            end
            ST_SHORT: begin
                st_d.result = st_q.short_val;
                st_d.done   = 1'b1;
                st_d.state  = ST_IDLE;
            end
            ST_DIVIDE: begin
                if (div_fin) begin
                    st_d.result = div_quot;
                    st_d.done   = 1'b1;
                    st_d.state  = ST_IDLE;
                end
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: ST_IDLE, short_val: '0, result: '0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy    = (st_q.state != ST_IDLE);
    assign done    = st_q.done;
    assign rate_hz = st_q.result;

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);                                         // R9
    AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);                              // R9
    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(rate_hz));                             // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                         // R8
    AST_FIN_ONLY_DIVIDING: assert property (@(posedge clk) disable iff (!rst_n)
        div_fin |-> (st_q.state == ST_DIVIDE));                  // R10

endmodule

// File: tb/test_pll_rate_decoder.sv
module test_pll_rate_decoder;

    localparam int QUO_W    = 64;
    localparam int LAT_DIV  = QUO_W + 2;   // edges counted including the accepting edge
    localparam int LAT_SHRT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] ctrl_word = '0;
    logic [31:0] ref_hz = '0;
    logic        busy;
    logic        done;
    logic [63:0] rate_hz;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pll_rate_decoder i_pll_rate_decoder (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .ctrl_word (ctrl_word),
        .ref_hz    (ref_hz),
        .busy      (busy),
        .done      (done),
        .rate_hz   (rate_hz)
    );

    function automatic longint unsigned model(input logic [31:0] cw, input logic [31:0] rf);
        longint unsigned num, den;
        if (cw[1]) return longint'(rf);
        if (cw[0]) return 0;
        num = longint'(rf) * (2 * (longint'(cw[15:9]) + 1));
        den = (longint'(cw[8:4]) + 1) << cw[3:2];
        return num / den;
    endfunction

    function automatic logic [31:0] pack(input int od, input int id, input int fb);
        return (32'(fb) << 9) | (32'(id) << 4) | (32'(od) << 2);
    endfunction

    function automatic int fb_pick(input int k);
        case (k)
            0: return 0;
            1: return 17;
            2: return 23;
            3: return 47;
            4: return 90;
            default: return 127;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input longint unsigned act,
                         input longint unsigned exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Issue one computation; optionally pulse a second start while busy.
    task automatic run_op(input logic [31:0] cw, input logic [31:0] rf, input bit inject,
                          input string req);
        longint unsigned exp;
        int  lat;
        int  exp_lat;
        bit  busy_ok;
        exp = model(cw, rf);
        exp_lat = (cw[1] || cw[0]) ? LAT_SHRT : LAT_DIV;
        busy_ok = 1'b1;
        @(negedge clk);
        start = 1'b1;
        ctrl_word = cw;
        ref_hz = rf;
        @(posedge clk);
        lat = 1;
        forever begin
            @(negedge clk);
            start = 1'b0;
            if (inject && lat == 1) begin
                start = 1'b1;                 // R10: ignored while busy
                ctrl_word = 32'h0000_0002;    // pass-through would give rf
                ref_hz = 32'd12345;
            end
            if (done) break;
            if (!busy) busy_ok = 1'b0;
            if (lat > 200) break;
            @(posedge clk);
            lat++;
        end
        start = 1'b0;
        check(rate_hz == exp, req, rate_hz, exp);
        check(lat == exp_lat, "R8 latency", lat, exp_lat);
        check(busy_ok && !busy, "R9 busy window", busy, 0);
        @(negedge clk);
        check(!done, "R8 done single cycle", done, 0);
        check(rate_hz == exp, "R10 result held", rate_hz, exp);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check(busy == 1'b0 && done == 1'b0 && rate_hz == 64'd0, "R11 reset", rate_hz, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, "R11 idle after reset", busy, 0);

        // R1: pass-through, with and without shut-down bit
        run_op(32'h0000_0002, 32'd33333333, 1'b0, "R1 pass");
        run_op(32'h0000_0003, 32'd27000000, 1'b0, "R1 pass over shut");
        run_op(pack(1, 0, 23) | 32'h2, 32'd33333333, 1'b0, "R1 pass ignores fields");
        // R2: shut-down
        run_op(32'h0000_0001, 32'd33333333, 1'b0, "R2 shut");
        run_op(pack(3, 31, 127) | 32'h1, 32'd27000000, 1'b0, "R2 shut ignores fields");

        // R6: example setting near 800 MHz
        run_op(pack(1, 0, 23), 32'd33333333, 1'b0, "R6 800MHz setting");
        // R6: largest product / smallest divisor, and largest divisor
        run_op(pack(0, 0, 127), 32'hFFFF_FFFF, 1'b0, "R6 max product");
        run_op(pack(3, 31, 0), 32'd27000000, 1'b0, "R6 max divisor");

        // R7: upper bits have no effect
        run_op(pack(2, 5, 47) | 32'hFFFF_0000, 32'd33333333, 1'b0, "R7 upper ones");
        run_op(pack(0, 1, 26) | 32'h00A5_0000, 32'd27000000, 1'b0, "R7 band bits");

        // R10: start while busy is ignored
        run_op(pack(1, 1, 44), 32'd33333333, 1'b1, "R10 start while busy");
        run_op(32'h0000_0001, 32'd27000000, 1'b1, "R10 start while short busy");

        // R3 R4 R5 R6: sweep post, pre and a spread of loop fields, both references
        for (int r = 0; r < 2; r++) begin
            for (int od = 0; od < 4; od++) begin
                for (int id = 0; id < 32; id++) begin
                    for (int k = 0; k < 6; k++) begin
                        run_op(pack(od, id, fb_pick(k)),
                               (r == 0) ? 32'd27000000 : 32'd33333333, 1'b0,
                               "R3 R4 R5 R6 sweep");
                    end
                end
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule